// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write strobe timing for programmed-I/O transfers on two IDE channels that carry four drives between them. A host-side agent loads per-drive timing bytes through a small register write port. It then requests a transfer by naming a drive, a direction and whether the access targets the command register block. The block steps through three phases, each counted in bus clocks. First comes address setup. Next is the active phase, during which exactly one strobe is high. Last is recovery, which ends with a one-clock done pulse.

The setup length is a 2-bit code that does not map linearly to clocks. The active and recovery lengths are nibbles of a packed byte, and a zero nibble stands for sixteen clocks. Small counts are raised to safe minimums. The primary drives each have their own timing bytes. The two secondary drives share a single set. Command-block accesses take their active and recovery lengths from a separate byte. A build parameter selects the silicon revision, and revisions above 1 stretch recovery by one clock.

Top module: `pio_cycle_gen`

## Requirements
- R1: The setup length comes from bits 7:6 of the drive's setup byte: code 00 gives 4 clocks, 10 gives 3, 01 gives 2 and 11 gives 5.
- R2: The active length is the upper nibble of the data-timing byte. A nibble of 0 means 16 clocks, and a nibble of 1 means 2 clocks.
- R3: The recovery length is the lower nibble of the data-timing byte, and a nibble of 0 means 16 clocks. A nibble of 1 means 2 clocks when the effective active length exceeds 3, and 1 clock otherwise.
- R4: With the revision parameter REV greater than 1, recovery lasts one clock longer than R3 gives. With REV equal to 1, it lasts exactly what R3 gives.
- R5: The register addresses are fixed. Address 0 is drive 0 setup and 1 is drive 0 data. Address 2 is drive 1 setup and 3 is drive 1 data. Address 4 is the setup byte shared by drives 2 and 3, and 5 is their shared data byte. Address 6 is the command-timing byte. Writing one drive's registers does not change another bank's timing.
- R6: A request with req_cmd high takes its active and recovery lengths from the command-timing byte and its setup length from the drive's own setup code. A command-timing value of 0 gives 16 active and 16 recovery clocks.
- R7: After reset, every register reads 0, so each drive runs 4 setup, 16 active and 16 recovery clocks.
- R8: Bits 5:0 of each setup register read back exactly as written and have no effect on timing.
- R9: During the active phase, rd_strobe is high for a read and wr_strobe is high for a write. The other strobe stays low for the whole transfer, and neither strobe is high in setup or recovery.
- R10: ack is high in the clock a request is taken, which happens only while the block is idle. done is a single-clock pulse on the last recovery clock. A request raised while busy gets no ack and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| req | input | 1 | Transfer request |
| req_drive | input | 2 | Drive index of the request |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_cmd | input | 1 | 1 = command-block access |
| ack | output | 1 | Request accepted this clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last recovery clock |
| cur_drive | output | 2 | Drive of the transfer in progress |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |

## Verification
The bench instantiates the block twice, once with REV left at 2 and once with REV set to 1. Both copies receive the same stimulus. Each transfer is therefore measured under both recovery rules, and the one-clock stretch can be told apart from a plain recovery count. The instances also share every nibble corner: a zero nibble, an active count of 1, and a recovery count of 1 behind both a short and a long active phase.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int NUM_DRIVES = 4;
    localparam int NUM_BANKS  = 3;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int CNT_W      = 5;
    localparam int DRV_W      = $clog2(NUM_DRIVES);
    localparam int BANK_W     = $clog2(NUM_BANKS);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(2 * NUM_BANKS);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } phase_len_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b00:   n = CNT_W'(4);
            2'b10:   n = CNT_W'(3);
            2'b01:   n = CNT_W'(2);
            default: n = CNT_W'(5);
        endcase
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] nibble_clocks(input logic [3:0] nib);
        return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
    endfunction

    function automatic logic [BANK_W-1:0] drive_bank(input logic [DRV_W-1:0] drv);
        return drv[1] ? BANK_W'(2) : BANK_W'(drv[0]);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        bank_setup_code [NUM_BANKS],
    output logic [DATA_W-1:0] bank_data       [NUM_BANKS],
    output logic [DATA_W-1:0] cmd_data
);

    logic [DATA_W-1:0] setup_q [NUM_BANKS];
    logic [DATA_W-1:0] data_q  [NUM_BANKS];
    logic [DATA_W-1:0] cmd_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] SETUP_A = ADDR_W'(2 * b);
        localparam logic [ADDR_W-1:0] DATA_A  = ADDR_W'(2 * b + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                setup_q[b] <= '0;
                data_q[b]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == SETUP_A) setup_q[b] <= wr_data;
                if (wr_addr == DATA_A)  data_q[b]  <= wr_data;
            end
        end

        assign bank_setup_code[b] = setup_q[b][7:6];
        assign bank_data[b]       = data_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst)                                 cmd_q <= '0;
        else if (wr_en && wr_addr == CMD_ADDR)   cmd_q <= wr_data;
    end

    assign cmd_data = cmd_q;

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == ADDR_W'(2 * b))     rd_data = setup_q[b];
            if (rd_addr == ADDR_W'(2 * b + 1)) rd_data = data_q[b];
        end
        if (rd_addr == CMD_ADDR) rd_data = cmd_q;
    end

    // R7: the first clock after reset shows cleared timing
    a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_q == '0 && data_q[0] == '0 && setup_q[2] == '0));

    // R5: no write leaves the command byte unchanged
    a_r5_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(cmd_q));

endmodule

// File: rtl/pio_phase_calc.sv
module pio_phase_calc
    import pio_timing_pkg::*;
#(
    parameter int unsigned REV = 2
) (
    input  logic [1:0]        setup_code,
    input  logic [DATA_W-1:0] timing_byte,
    output phase_len_t        lens
);

    logic [CNT_W-1:0] act_raw, act_eff, rec_raw, rec_fix;

    always_comb begin
        act_raw = nibble_clocks(timing_byte[7:4]);
        act_eff = (act_raw == CNT_W'(1)) ? CNT_W'(2) : act_raw;
        rec_raw = nibble_clocks(timing_byte[3:0]);
        rec_fix = (rec_raw == CNT_W'(1) && act_eff > CNT_W'(3)) ? CNT_W'(2) : rec_raw;
    end

    assign lens.setup  = setup_clocks(setup_code);
    assign lens.active = act_eff;

    if (REV > 1) begin : g_rev_late
        assign lens.recov = rec_fix + CNT_W'(1);
    end else begin : g_rev_early
        assign lens.recov = rec_fix;
    end

    always_comb begin
        // R2: the active phase never drops below two clocks
        a_r2_active_floor: assert (lens.active >= CNT_W'(2) || $isunknown(timing_byte));
        // R4: a late revision always gives at least two recovery clocks
        a_r4_recov_floor: assert (REV <= 1 || lens.recov >= CNT_W'(2) || $isunknown(timing_byte));
    end

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [DRV_W-1:0] req_drive,
    input  logic             req_write,
    input  phase_len_t       lens_in,
    output logic             ack,
    output logic             busy,
    output logic             done,
    output logic [DRV_W-1:0] cur_drive,
    output logic             rd_strobe,
    output logic             wr_strobe
);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q, rec_q;
    logic             write_q;
    logic [DRV_W-1:0] drv_q;
    logic             last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            rec_q   <= '0;
            write_q <= 1'b0;
            drv_q   <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (req) begin
                    act_q   <= lens_in.active;
                    rec_q   <= lens_in.recov;
                    write_q <= req_write;
                    drv_q   <= req_drive;
                    cnt_q   <= lens_in.setup - CNT_W'(1);
                    ph_q    <= PH_SETUP;
                end
                PH_SETUP: if (last) begin
                    cnt_q <= act_q - CNT_W'(1);
                    ph_q  <= PH_ACTIVE;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_ACTIVE: if (last) begin
                    cnt_q <= rec_q - CNT_W'(1);
                    ph_q  <= PH_RECOV;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_RECOV: if (last) begin
                    ph_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            endcase
        end
    end

    assign ack       = req && (ph_q == PH_IDLE);
    assign busy      = (ph_q != PH_IDLE);
    assign done      = (ph_q == PH_RECOV) && last;
    assign cur_drive = drv_q;
    assign rd_strobe = (ph_q == PH_ACTIVE) && !write_q;
    assign wr_strobe = (ph_q == PH_ACTIVE) &&  write_q;

    // R10: an accepted request makes the block busy on the next clock
    a_r10_ack_starts: assert property (@(posedge clk) disable iff (rst)
        ack |=> busy);

    // R10: the done clock is followed by idle
    a_r10_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R9: the two strobes are never high together
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe && wr_strobe));

    // R9: a strobe never rises straight out of idle
    a_r9_setup_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_strobe) || $rose(wr_strobe)) |-> $past(busy));

    // R10: the drive stays fixed while a transfer runs
    a_r10_drive_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_drive));

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_timing_pkg::*;
#(
    parameter int unsigned REV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        req,
    input  logic [1:0]  req_drive,
    input  logic        req_write,
    input  logic        req_cmd,
    output logic        ack,
    output logic        busy,
    output logic        done,
    output logic [1:0]  cur_drive,
    output logic        rd_strobe,
    output logic        wr_strobe
);

    logic [1:0]        bank_setup_code [NUM_BANKS];
    logic [DATA_W-1:0] bank_data       [NUM_BANKS];
    logic [DATA_W-1:0] cmd_data;
    logic [BANK_W-1:0] sel_bank;
    logic [1:0]        sel_setup;
    logic [DATA_W-1:0] sel_timing;
    phase_len_t        lens;

    pio_timing_regs u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .rd_addr         (rd_addr),
        .rd_data         (rd_data),
        .bank_setup_code (bank_setup_code),
        .bank_data       (bank_data),
        .cmd_data        (cmd_data)
    );

    always_comb begin
        sel_bank   = drive_bank(req_drive);
        sel_setup  = bank_setup_code[sel_bank];
        sel_timing = req_cmd ? cmd_data : bank_data[sel_bank];
    end

    pio_phase_calc #(.REV(REV)) u_calc (
        .setup_code  (sel_setup),
        .timing_byte (sel_timing),
        .lens        (lens)
    );

    pio_strobe_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_drive (req_drive),
        .req_write (req_write),
        .lens_in   (lens),
        .ack       (ack),
        .busy      (busy),
        .done      (done),
        .cur_drive (cur_drive),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );

endmodule

// File: tb/tb_pio_cycle_gen.sv
module tb_pio_cycle_gen;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int setup;
        int active;
        int recov;
        bit write;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic req = 1'b0;
    logic [1:0] req_drive = '0;
    logic req_write = 1'b0;
    logic req_cmd = 1'b0;

    logic [7:0] rd_data, rd_data1;
    logic ack [2], busy [2], done [2], rds [2], wrs [2];
    logic [1:0] cdrv [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cycle_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .req(req), .req_drive(req_drive),
        .req_write(req_write), .req_cmd(req_cmd), .ack(ack[0]), .busy(busy[0]),
        .done(done[0]), .cur_drive(cdrv[0]), .rd_strobe(rds[0]), .wr_strobe(wrs[0])
    );

    pio_cycle_gen #(.REV(1)) dut_r1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data1), .req(req), .req_drive(req_drive),
        .req_write(req_write), .req_cmd(req_cmd), .ack(ack[1]), .busy(busy[1]),
        .done(done[1]), .cur_drive(cdrv[1]), .rd_strobe(rds[1]), .wr_strobe(wrs[1])
    );

    int n_tests = 0;
    int n_fail  = 0;

    exp_t q_rev2 [$];
    exp_t q_rev1 [$];

    logic [7:0] sh_setup [3];
    logic [7:0] sh_data  [3];
    logic [7:0] sh_cmd;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [7:0] s, input logic [7:0] d,
                                   input int rev, input bit wr, input string tag);
        exp_t e;
        case (s[7:6])
            2'b00:   e.setup = 4;
            2'b10:   e.setup = 3;
            2'b01:   e.setup = 2;
            default: e.setup = 5;
        endcase
        e.active = (d[7:4] == 0) ? 16 : int'(d[7:4]);
        if (e.active == 1) e.active = 2;
        e.recov = (d[3:0] == 0) ? 16 : int'(d[3:0]);
        if (e.recov == 1 && e.active > 3) e.recov = 2;
        if (rev > 1) e.recov++;
        e.write = wr;
        e.tag = tag;
        return e;
    endfunction

    // monitor: phase counters per instance
    int c_set [2], c_act [2], c_rec [2], c_bad [2];

    initial begin
        for (int k = 0; k < 2; k++) begin
            c_set[k] = 0; c_act[k] = 0; c_rec[k] = 0; c_bad[k] = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                if (!busy[k] && (rds[k] || wrs[k])) c_bad[k]++;
                if (busy[k]) begin
                    if (rds[k] || wrs[k]) begin
                        c_act[k]++;
                        if (rds[k] && wrs[k]) c_bad[k]++;
                    end else if (c_act[k] == 0) begin
                        c_set[k]++;
                    end else begin
                        c_rec[k]++;
                    end
                end
                if (done[k]) begin
                    exp_t e;
                    bit have;
                    have = (k == 0) ? (q_rev2.size() > 0) : (q_rev1.size() > 0);
                    if (!have) begin
                        check(1'b0, "R10 unexpected transfer", 1, 0);
                    end else begin
                        e = (k == 0) ? q_rev2.pop_front() : q_rev1.pop_front();
                        check(c_set[k] == e.setup, {e.tag, " setup"}, c_set[k], e.setup);
                        check(c_act[k] == e.active, {e.tag, " active"}, c_act[k], e.active);
                        check(c_rec[k] == e.recov, {e.tag, (k == 0) ? " recov R4 rev2" : " recov R4 rev1"},
                              c_rec[k], e.recov);
                        check(c_bad[k] == 0, {e.tag, " R9 strobe misuse"}, c_bad[k], 0);
                    end
                    c_set[k] = 0; c_act[k] = 0; c_rec[k] = 0; c_bad[k] = 0;
                end
            end
        end
    end

    // R9: direction of strobe must match the request
    bit cur_wr = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                if (busy[k] && ((cur_wr && rds[k]) || (!cur_wr && wrs[k])))
                    c_bad[k]++;
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd6) sh_cmd = d;
        else if (a[0]) sh_data[a[2:1]] = d;
        else sh_setup[a[2:1]] = d;
    endtask

    task automatic xfer(input logic [1:0] drv, input bit wr, input bit cmd, input string tag);
        int bank;
        logic [7:0] d;
        bank = drv[1] ? 2 : int'(drv[0]);
        d = cmd ? sh_cmd : sh_data[bank];
        @(negedge clk);
        req = 1'b1; req_drive = drv; req_write = wr; req_cmd = cmd;
        cur_wr = wr;
        #1;
        check(ack[0] && ack[1], {tag, " R10 ack"}, int'(ack[0]), 1);
        q_rev2.push_back(model(sh_setup[bank], d, 2, wr, tag));
        q_rev1.push_back(model(sh_setup[bank], d, 1, wr, tag));
        @(negedge clk);
        req = 1'b0;
        check(cdrv[0] == drv, {tag, " R10 cur_drive"}, int'(cdrv[0]), int'(drv));
        while (busy[0] || busy[1]) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int b = 0; b < 3; b++) begin
            sh_setup[b] = '0; sh_data[b] = '0;
        end
        sh_cmd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7: reset state
        for (int a = 0; a < 7; a++) begin
            rd_addr = 3'(a);
            #1;
            check(rd_data == 8'h00, "R7 reset readback", int'(rd_data), 0);
        end
        check(!busy[0] && !rds[0] && !wrs[0], "R7 idle after reset", int'(busy[0]), 0);
        xfer(2'd0, 1'b0, 1'b0, "R7 default drive0");
        xfer(2'd3, 1'b1, 1'b0, "R7 default drive3");

        // R1: every setup code
        reg_write(3'd1, 8'h23);
        for (int c = 0; c < 4; c++) begin
            reg_write(3'd0, {2'(c), 6'b0});
            xfer(2'd0, c[0], 1'b0, $sformatf("R1 setup code %0d", c));
        end

        // R2 / R3: nibble corners
        reg_write(3'd0, 8'h40);
        reg_write(3'd1, 8'h11); xfer(2'd0, 1'b0, 1'b0, "R2 R3 act1 rec1");
        reg_write(3'd1, 8'h41); xfer(2'd0, 1'b1, 1'b0, "R3 act4 rec1");
        reg_write(3'd1, 8'h31); xfer(2'd0, 1'b0, 1'b0, "R3 act3 rec1");
        reg_write(3'd1, 8'h10); xfer(2'd0, 1'b1, 1'b0, "R2 act1 rec0");
        reg_write(3'd1, 8'h0F); xfer(2'd0, 1'b0, 1'b0, "R2 act0 recF");
        reg_write(3'd1, 8'hF2); xfer(2'd0, 1'b1, 1'b0, "R9 write actF");

        // R5: drive1 independent, drive0 unchanged
        reg_write(3'd2, 8'hC0);
        reg_write(3'd3, 8'h52);
        xfer(2'd1, 1'b0, 1'b0, "R5 drive1 own");
        xfer(2'd0, 1'b0, 1'b0, "R5 drive0 kept");
        // R5: secondary share
        reg_write(3'd4, 8'h80);
        reg_write(3'd5, 8'h63);
        xfer(2'd2, 1'b1, 1'b0, "R5 drive2 shared");
        xfer(2'd3, 1'b0, 1'b0, "R5 drive3 shared");

        // R6: command timing
        reg_write(3'd6, 8'h32);
        xfer(2'd1, 1'b0, 1'b1, "R6 cmd drive1");
        xfer(2'd2, 1'b1, 1'b1, "R6 cmd drive2");
        reg_write(3'd6, 8'h00);
        xfer(2'd0, 1'b0, 1'b1, "R6 cmd zero slowest");

        // R8: low bits stored, timing from top bits only
        reg_write(3'd0, 8'hAA);
        rd_addr = 3'd0;
        #1;
        check(rd_data == 8'hAA, "R8 setup readback", int'(rd_data), 8'hAA);
        check(rd_data1 == 8'hAA, "R8 setup readback rev1", int'(rd_data1), 8'hAA);
        reg_write(3'd1, 8'h22);
        xfer(2'd0, 1'b1, 1'b0, "R8 low bits ignored");
        reg_write(3'd4, 8'h3F);
        rd_addr = 3'd4;
        #1;
        check(rd_data == 8'h3F, "R8 shared readback", int'(rd_data), 8'h3F);
        xfer(2'd2, 1'b0, 1'b0, "R8 shared code00");

        // R10: request while busy is ignored
        @(negedge clk);
        req = 1'b1; req_drive = 2'd0; req_write = 1'b0; req_cmd = 1'b0; cur_wr = 1'b0;
        #1;
        q_rev2.push_back(model(sh_setup[0], sh_data[0], 2, 1'b0, "R10 first"));
        q_rev1.push_back(model(sh_setup[0], sh_data[0], 1, 1'b0, "R10 first"));
        @(negedge clk);
        req_drive = 2'd1;
        repeat (3) @(negedge clk);
        #1;
        check(!ack[0] && !ack[1], "R10 no ack while busy", int'(ack[0]), 0);
        req = 1'b0;
        while (busy[0] || busy[1]) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy[0] && !busy[1], "R10 no extra transfer", int'(busy[0]), 0);
        check(q_rev2.size() == 0 && q_rev1.size() == 0, "R10 queue drained",
              q_rev2.size() + q_rev1.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule